// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

A register-mapped watchdog built around a down counter. Once enabled, the counter is loaded from a timeout register and counts down by one on every clock. If software lets it reach zero, a sticky timeout flag is raised and the count starts again from the timeout value. Software keeps the flag from being raised by servicing the watchdog. To service it, software writes an ordered pair of 16-bit words to a service-code register, and that pair reloads the counter.

There are two kinds of service pair. In the default mode the pair is fixed. In keyed mode each word of the pair comes from a pseudorandom step applied to a software-seeded key. A separate fixed pair, written to the same register, clears a soft lock. While the soft lock is set, the control and timeout registers are frozen. A counter-output register exposes the count only while the watchdog is disabled, so software can inspect it after stopping the timer.

Word registers, selected by `addr[4:2]`: 0 control, 1 timeout, 2 service code, 3 status, 4 key, 5 counter output. Control bits: bit 0 enable, bit 1 keyed mode, bit 4 soft lock. Status bit 0 is the timeout flag.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, reads return 0 from the control, status, key and counter-output registers, and the timeout register reads its default of 256.
- R2: In the default mode, writing 0xA602 and then 0xB480 as consecutive service-code writes reloads the counter from the timeout register on the edge of the second write.
- R3: A service-code write that does not match the word the checker expects returns the checker to idle without servicing. A lone 0xB480 does not service, and 0xA602 followed by any other word and then 0xB480 does not service.
- R4: While the soft lock is set, writing 0xC520 and then 0xD928 as consecutive service-code writes clears it. If any other service-code write comes between the two words, the lock is not cleared.
- R5: Writing 1 to control bit 4 sets the soft lock. While the lock is set, writes to the control and timeout registers have no effect.
- R6: In keyed mode (control bit 1), the first expected word is k1 = (17*K + 3) mod 65536 and the second is k2 = (17*k1 + 3) mod 65536, where K is the key register. A successful keyed service reloads the counter and stores k2 in the key register. The fixed default pair does not service in keyed mode.
- R7: The counter-output register returns the live count while the enable bit is 0 and returns 0 while the enable bit is 1.
- R8: A control write that turns the enable bit from 0 to 1 loads the counter from the timeout register. While enabled, the counter decrements once per clock, and this includes the edge of the write that disables it. While disabled, it holds its value.
- R9: When the counter is at zero while enabled, the timeout flag (status bit 0, and the `timeout_o` output) is set, and the counter reloads from the timeout register on that same edge.
- R10: The timeout flag stays set until 1 is written to status bit 0. Writing 0 leaves it set.
- R11: A service-code write uses only the low 16 bits of the data, and the upper 16 bits are ignored. Reads of the service-code register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe, one write per asserted cycle |
| addr | input | 5 | Byte address, with the word selected by bits 4:2 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
The hardest state to observe from the ports is the count itself while the watchdog is running, because the counter-output register reads zero whenever the timer is enabled. The bench therefore times each scenario so that the timer starts, services and stops on known edges, and only reads the counter after a disabling write. The remaining value shows whether a reload happened, and on which edge. The keyed-mode words and the expected new key are computed in the bench from the stated recurrence, starting from a seed it chooses.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [2:0] {
    RI_CTRL = 3'd0,
    RI_TMO  = 3'd1,
    RI_SVC  = 3'd2,
    RI_STAT = 3'd3,
    RI_KEY  = 3'd4,
    RI_CNT  = 3'd5
  } reg_idx_e;

  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_KEY  = 1;
  localparam int unsigned CB_LOCK = 4;

  localparam logic [15:0] SVC_W1 = 16'hA602;
  localparam logic [15:0] SVC_W2 = 16'hB480;
  localparam logic [15:0] UNL_W1 = 16'hC520;
  localparam logic [15:0] UNL_W2 = 16'hD928;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SVC  = 2'd1,
    SQ_UNL  = 2'd2
  } seq_st_e;

  // one pseudorandom step: 17*k + 3, wrapping at 16 bits
  function automatic logic [15:0] key_step(input logic [15:0] k);
    logic [15:0] r;
    r = (k << 4) + k + 16'd3;
    return r;
  endfunction
endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/wdg_seq.sv
module wdg_seq
  import wdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        code_we,
  input  logic [15:0] code,
  input  logic        keyed,
  input  logic [15:0] key_q,
  output logic        svc_ok,
  output logic        unl_ok,
  output logic [15:0] key_next
);
  seq_st_e st_q, st_d;
  logic [15:0] k1, k2, exp1, exp2;

  always_comb begin
    k1       = key_step(key_q);
    k2       = key_step(k1);
    exp1     = keyed ? k1 : SVC_W1;
    exp2     = keyed ? k2 : SVC_W2;
    key_next = k2;
  end

  always_comb begin
    st_d   = st_q;
    svc_ok = 1'b0;
    unl_ok = 1'b0;
    if (code_we) begin
      unique case (st_q)
        SQ_IDLE: begin
          if (code == exp1)        st_d = SQ_SVC;
          else if (code == UNL_W1) st_d = SQ_UNL;
          else                     st_d = SQ_IDLE;
        end
        SQ_SVC: begin
          st_d   = SQ_IDLE;
          svc_ok = (code == exp2);
        end
        SQ_UNL: begin
          st_d   = SQ_IDLE;
          unl_ok = (code == UNL_W2);
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wdg_cnt.sv
module wdg_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (load) begin
      cnt_d = reload_val;
    end else if (en) begin
      if (cnt_q == '0) begin
        expire = 1'b1;
        cnt_d  = reload_val;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter logic [31:0] TMO_RST = 32'd256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              timeout_o
);
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned DATA_W = 32;

  logic rst_q_n;
  logic [IDX_W-1:0] idx;
  logic wr_ctrl, wr_tmo, wr_svc, wr_stat, wr_key;

  logic en_q, en_d, keyed_q, keyed_d, lock_q, lock_d, flag_q, flag_d;
  logic [CNT_W-1:0] tmo_q, tmo_d, count;
  logic [15:0] key_q, key_d, key_next;
  logic svc_ok, unl_ok, load, start_load, expire;

  logic unused_bits;
  assign unused_bits = ^{addr[1:0], wdata[31:16], wdata[3:2]};

  wdg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  assign idx     = addr[ADDR_W-1:2];
  assign wr_ctrl = wr_en && (idx == IDX_W'(RI_CTRL)) && !lock_q;
  assign wr_tmo  = wr_en && (idx == IDX_W'(RI_TMO))  && !lock_q;
  assign wr_svc  = wr_en && (idx == IDX_W'(RI_SVC));
  assign wr_stat = wr_en && (idx == IDX_W'(RI_STAT));
  assign wr_key  = wr_en && (idx == IDX_W'(RI_KEY));

  wdg_seq u_seq (
    .clk(clk), .rst_n(rst_q_n),
    .code_we(wr_svc), .code(wdata[15:0]),
    .keyed(keyed_q), .key_q(key_q),
    .svc_ok(svc_ok), .unl_ok(unl_ok), .key_next(key_next)
  );

  assign start_load = wr_ctrl && wdata[CB_EN] && !en_q;
  assign load       = start_load || svc_ok;

  wdg_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_q_n),
    .en(en_q), .load(load), .reload_val(tmo_q),
    .count(count), .expire(expire)
  );

  // next-state for the register file
  always_comb begin
    en_d    = en_q;
    keyed_d = keyed_q;
    tmo_d   = tmo_q;
    key_d   = key_q;
    flag_d  = flag_q;
    if (wr_ctrl) begin
      en_d    = wdata[CB_EN];
      keyed_d = wdata[CB_KEY];
    end
    if (lock_q) lock_d = !unl_ok;
    else        lock_d = wr_ctrl && wdata[CB_LOCK];
    if (wr_tmo) tmo_d = wdata[CNT_W-1:0];
    if (wr_key)                  key_d = wdata[15:0];
    else if (svc_ok && keyed_q)  key_d = key_next;
    if (expire)                     flag_d = 1'b1;
    else if (wr_stat && wdata[0])   flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      en_q    <= 1'b0;
      keyed_q <= 1'b0;
      lock_q  <= 1'b0;
      tmo_q   <= TMO_RST[CNT_W-1:0];
      key_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      en_q    <= en_d;
      keyed_q <= keyed_d;
      lock_q  <= lock_d;
      tmo_q   <= tmo_d;
      key_q   <= key_d;
      flag_q  <= flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (idx)
      IDX_W'(RI_CTRL): begin
        rdata[CB_EN]   = en_q;
        rdata[CB_KEY]  = keyed_q;
        rdata[CB_LOCK] = lock_q;
      end
      IDX_W'(RI_TMO):  rdata = DATA_W'(tmo_q);
      IDX_W'(RI_STAT): rdata[0] = flag_q;
      IDX_W'(RI_KEY):  rdata = DATA_W'(key_q);
      IDX_W'(RI_CNT):  rdata = en_q ? '0 : DATA_W'(count);
      default:         rdata = '0;
    endcase
  end

  assign timeout_o = flag_q;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              en_q,
  input logic              keyed_q,
  input logic              lock_q,
  input logic              flag_q,
  input logic              load,
  input logic              svc_ok,
  input logic [CNT_W-1:0]  tmo_q,
  input logic [CNT_W-1:0]  count
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:2];

  a_r7_cnt_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && idx == IDX_W'(RI_CNT)) |-> (rdata == '0));

  a_r5_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && idx == IDX_W'(RI_CTRL)) |=> ($stable(en_q) && $stable(keyed_q)));

  a_r5_tmo_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && idx == IDX_W'(RI_TMO)) |=> $stable(tmo_q));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !load) |=> $stable(count));

  a_r9_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && count == '0 && !load) |=> (flag_q && count == $past(tmo_q)));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_en && idx == IDX_W'(RI_STAT) && wdata[0])) |=> flag_q);

  a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |=> (count == $past(tmo_q)));
endmodule

bind svc_watchdog wdg_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .en_q(en_q), .keyed_q(keyed_q), .lock_q(lock_q),
  .flag_q(flag_q), .load(load), .svc_ok(svc_ok), .tmo_q(tmo_q), .count(count)
);

// File: tb/sim_svc_watchdog.sv
module sim_svc_watchdog;
  localparam time HALF = 10ns;

  logic        clk, rst_n, wr_en, timeout_o;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  int total, bad;

  svc_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .timeout_o(timeout_o)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  localparam logic [2:0] I_CTRL = 3'd0, I_TMO = 3'd1, I_SVC = 3'd2,
                         I_STAT = 3'd3, I_KEY = 3'd4, I_CNT = 3'd5;

  function automatic logic [15:0] step(input logic [15:0] k);
    return 16'((32'(k) * 32'd17 + 32'd3) % 32'd65536);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = {idx, 2'b00}; wdata = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    addr = {idx, 2'b00};
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(I_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(I_TMO, v);  chk("R1 tmo", v, 32'd256);
    rd(I_STAT, v); chk("R1 stat", v, 32'h0);
    rd(I_KEY, v);  chk("R1 key", v, 32'h0);
    rd(I_CNT, v);  chk("R1 cnt", v, 32'h0);
    chk("R1 timeout_o", {31'b0, timeout_o}, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] v, w;
    wr(I_TMO, 32'd100);
    wr(I_CTRL, 32'h1);
    idle(9);
    wr(I_CTRL, 32'h0);
    rd(I_CNT, v); chk("R8 decrement per clock", v, 32'd90);
    rd(I_CNT, w); chk("R8 hold when disabled", w, 32'd90);
    wr(I_CTRL, 32'h1);
    rd(I_CNT, v); chk("R7 reads zero while enabled", v, 32'h0);
    wr(I_CTRL, 32'h0);
  endtask

  task automatic t_service();
    logic [31:0] v;
    wr(I_CTRL, 32'h1);
    idle(10);
    wr(I_SVC, 32'h0000_A602);
    wr(I_SVC, 32'h0000_B480);
    wr(I_CTRL, 32'h0);
    rd(I_CNT, v); chk("R2 fixed pair reloads", v, 32'd99);
  endtask

  task automatic t_badseq();
    logic [31:0] v;
    wr(I_CTRL, 32'h1);
    wr(I_SVC, 32'h0000_A602);
    wr(I_SVC, 32'h0000_1234);
    wr(I_SVC, 32'h0000_B480);
    wr(I_CTRL, 32'h0);
    rd(I_CNT, v); chk("R3 interrupted pair ignored", v, 32'd96);
    wr(I_CTRL, 32'h1);
    wr(I_SVC, 32'h0000_B480);
    wr(I_CTRL, 32'h0);
    rd(I_CNT, v); chk("R3 lone second word ignored", v, 32'd98);
    wr(I_CTRL, 32'h1);
    wr(I_SVC, 32'hFFFF_A602);
    wr(I_SVC, 32'h5A5A_B480);
    wr(I_SVC, 32'h0);
    wr(I_CTRL, 32'h0);
    rd(I_CNT, v); chk("R11 upper bits ignored", v, 32'd98);
    rd(I_SVC, v); chk("R11 service reads zero", v, 32'h0);
  endtask

  task automatic t_expire();
    logic [31:0] v;
    wr(I_TMO, 32'd5);
    wr(I_CTRL, 32'h1);
    idle(7);
    wr(I_CTRL, 32'h0);
    rd(I_CNT, v); chk("R9 reload after zero", v, 32'd3);
    rd(I_STAT, v); chk("R9 flag set", v, 32'h1);
    chk("R9 timeout_o", {31'b0, timeout_o}, 32'h1);
    wr(I_STAT, 32'h0);
    rd(I_STAT, v); chk("R10 write 0 keeps flag", v, 32'h1);
    wr(I_STAT, 32'h1);
    rd(I_STAT, v); chk("R10 write 1 clears flag", v, 32'h0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(I_CTRL, 32'h10);
    rd(I_CTRL, v); chk("R5 lock set", v, 32'h10);
    wr(I_TMO, 32'h55);
    rd(I_TMO, v); chk("R5 tmo frozen", v, 32'd5);
    wr(I_CTRL, 32'h1);
    rd(I_CTRL, v); chk("R5 ctrl frozen", v, 32'h10);
    rd(I_CNT, v); chk("R5 counter not started", v, 32'd3);
    wr(I_SVC, 32'hC520);
    wr(I_SVC, 32'hA602);
    wr(I_SVC, 32'hD928);
    rd(I_CTRL, v); chk("R4 broken unlock keeps lock", v, 32'h10);
    wr(I_SVC, 32'hC520);
    wr(I_SVC, 32'hD928);
    rd(I_CTRL, v); chk("R4 unlock clears lock", v, 32'h0);
    wr(I_TMO, 32'd100);
    rd(I_TMO, v); chk("R4 tmo writable again", v, 32'd100);
  endtask

  task automatic t_keyed();
    logic [31:0] v;
    logic [15:0] seed, k1, k2;
    seed = 16'h1234;
    k1 = step(seed);
    k2 = step(k1);
    wr(I_KEY, {16'h0, seed});
    wr(I_CTRL, 32'h3);
    wr(I_SVC, 32'h0000_A602);
    wr(I_SVC, 32'h0000_B480);
    wr(I_CTRL, 32'h0);
    rd(I_CNT, v); chk("R6 fixed pair rejected in keyed mode", v, 32'd97);
    wr(I_CTRL, 32'h3);
    wr(I_SVC, {16'h0, k1});
    wr(I_SVC, {16'h0, k2});
    wr(I_CTRL, 32'h0);
    rd(I_CNT, v); chk("R6 keyed pair reloads", v, 32'd99);
    rd(I_KEY, v); chk("R6 key advanced", v, {16'h0, k2});
  endtask

  initial begin
    #(HALF * 2 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_count();
    t_service();
    t_badseq();
    t_expire();
    t_lock();
    t_keyed();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule